// File: doc/BRIEF.md
# Prefixed Instruction Byte Framer

This block sits between an instruction byte source and a decoder for an 8-bit processor whose opcodes can carry prefix bytes. It takes one byte at a time and groups the bytes into complete instructions. It keeps track of which prefix is active: none, the bit-operation prefix (0xCB), the extended prefix (0xED), or one of the two index prefixes (0xDD for index X, 0xFD for index Y). From the fields of the opcode byte it works out whether a signed displacement and zero, one or two immediate bytes follow. Each finished instruction comes out as one record holding a class code, the final opcode, the displacement, the immediate, the total byte count (prefixes included) and the index-register select. The block does not execute instructions and does not fetch memory.

Both sides use valid/ready. An input byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A record is presented on `out_valid` and is taken on an edge where `out_ready` is also high. While a record is held without being taken, the record stays unchanged and `in_ready` is low, so no byte is taken. `in_ready` is high whenever no record is held, or when the held record is being taken in the same cycle. This lets a new byte enter in the cycle the old record leaves.

In the opcode fields below, grp = bits 7:6, mid = bits 5:3, low = bits 2:0, pr = bits 5:4 and qb = bit 3. Class codes on `rec_class` are: 0 plain, 1 bit-operation, 2 extended, 3 indexed, 4 indexed bit-operation, 5 dropped prefix, 6 invalid extended. `rec_disp` and `rec_imm` are zero wherever the instruction has no such bytes. `rec_idx_y` is 0 on records that do not come from an index prefix.

Top module: `prefix_framer`

## Requirements
- R1: A synchronous reset, even one applied partway through an instruction, clears `out_valid`, drives `in_ready` high and returns framing to the no-prefix state. The next byte taken is then treated as the first byte of a new instruction.
- R2: While `out_valid` is high and `out_ready` is low, every record field stays stable and `in_ready` is low. A byte offered during the stall is taken only once the record leaves, and it then frames correctly.
- R3: An unprefixed opcode that needs no operand bytes, such as 0x00 or 0x76, gives class 0, the opcode, length 1, disp 0 and imm 0.
- R4: An unprefixed opcode with one immediate byte gives class 0, imm = {0x00, byte}, length 2. These are: grp0/low0 with mid>=2; grp0/low6; grp3/low6; and grp3/low3 with mid 2 or 3.
- R5: An unprefixed opcode with a 16-bit immediate gives class 0 and length 3, with the first operand byte as imm[7:0]. These are: grp0/low1/qb0; grp0/low2 with mid>=4; grp3/low2; grp3/low4; grp3/low3/mid0; and grp3/low5/qb1/pr0.
- R6: 0xCB followed by any byte gives class 1, with that byte as the opcode and length 2.
- R7: 0xED followed by a valid opcode gives class 2. Valid opcodes are all of grp1, plus grp2 with mid>=4 and low<=3. Those with grp1/low3 carry a 16-bit immediate, low byte first, for length 4. All other valid ones have length 2.
- R8: 0xED followed by an opcode with grp0, grp3, or grp2 outside the valid block gives one record of class 6, with that opcode and length 2.
- R9: 0xDD or 0xFD followed by a non-prefix opcode gives class 3, with `rec_idx_y` = 0 for 0xDD and 1 for 0xFD. Its immediates follow the same rules as R4 and R5, with the prefix counted in the length.
- R10: Under an index prefix, an opcode that uses the memory operand takes a displacement byte right after the opcode, with any immediate after that. Memory-operand opcodes are: grp1 with low6 or mid6 but not both; grp2 with low6; and grp0 with mid6 and low 4, 5 or 6. The HALT opcode 0x76 takes no displacement.
- R11: An index prefix followed by 0xDD, 0xED or 0xFD gives a class 5 record. Its opcode is the discarded prefix byte, its length is 1, and `rec_idx_y` is that prefix's select. The new prefix byte then starts the next instruction and counts toward that instruction's length.
- R12: An index prefix, then 0xCB, then d, then an opcode gives class 4 and length 4, with d as `rec_disp` and the fourth byte as the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Framer can take a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Record is presented |
| out_ready | input | 1 | Consumer takes the record |
| rec_class | output | 3 | Record class code (see above) |
| rec_opcode | output | 8 | Final opcode byte, or the discarded prefix for class 5 |
| rec_disp | output | 8 | Signed displacement, 0 if none |
| rec_imm | output | 16 | Immediate, low byte in bits 7:0, 0 if none |
| rec_len | output | 3 | Total byte count, 1 to 4 |
| rec_idx_y | output | 1 | 1 selects index Y, 0 selects index X |

## Verification
The corner cases are the indexed forms, where the order of the bytes matters. If the displacement and the opcode were swapped in the four-byte bit form, the disp and opcode would come out exchanged. If the displacement were left off the indexed immediate store (0xDD 0x36 d n), the length would be 3 and d would land in the immediate. A framer that treated indexed HALT as a memory operand would swallow the next instruction's byte as a displacement. If the redundant-prefix case did not restart framing, the following instruction would get the wrong index select or length. Further checks cover the back-pressure stall and a byte offered during it, a reset in the middle of an instruction, the invalid extended opcodes, and the low-first order of 16-bit immediates.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int BYTE_W  = 8;
  localparam int IMM_W   = 2 * BYTE_W;
  localparam int MAX_LEN = 4;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = 2;

  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;

  typedef enum logic [2:0] {
    CLS_PLAIN     = 3'd0,
    CLS_BITOP     = 3'd1,
    CLS_EXT       = 3'd2,
    CLS_INDEX     = 3'd3,
    CLS_INDEX_BIT = 3'd4,
    CLS_DROPPED   = 3'd5,
    CLS_EXT_BAD   = 3'd6
  } rec_class_e;

  typedef enum logic [1:0] {
    SP_MAIN  = 2'd0,
    SP_EXT   = 2'd1,
    SP_INDEX = 2'd2
  } op_space_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BIT_OP,
    ST_EXT_OP,
    ST_IDX_OP,
    ST_IDXB_DISP,
    ST_IDXB_OP,
    ST_DISP,
    ST_IMM_LO,
    ST_IMM_HI
  } frame_state_e;

  typedef struct packed {
    rec_class_e        cls;
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] disp;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
    logic              idx_y;
  } frame_rec_t;
endpackage

// File: rtl/ifr_operand_decode.sv
module ifr_operand_decode
  import ifr_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  op_space_e         space,
  output logic [CNT_W-1:0]  imm_cnt,
  output logic              need_disp,
  output logic              ext_bad
);
  logic [1:0] grp;
  logic [2:0] mid;
  logic [2:0] low;
  logic [1:0] pr;
  logic       qb;

  assign grp = op[7:6];
  assign mid = op[5:3];
  assign low = op[2:0];
  assign pr  = op[5:4];
  assign qb  = op[3];

  logic [CNT_W-1:0] main_cnt;

  always_comb begin
    main_cnt = '0;
    unique case (grp)
      2'd0: begin
        if (low == 3'd1 && !qb)               main_cnt = 2'd2;
        else if (low == 3'd2 && mid >= 3'd4)  main_cnt = 2'd2;
        else if (low == 3'd0 && mid >= 3'd2)  main_cnt = 2'd1;
        else if (low == 3'd6)                 main_cnt = 2'd1;
      end
      2'd3: begin
        if (low == 3'd2 || low == 3'd4)              main_cnt = 2'd2;
        else if (low == 3'd3 && mid == 3'd0)         main_cnt = 2'd2;
        else if (low == 3'd5 && qb && pr == 2'd0)    main_cnt = 2'd2;
        else if (low == 3'd6)                        main_cnt = 2'd1;
        else if (low == 3'd3 && (mid == 3'd2 || mid == 3'd3)) main_cnt = 2'd1;
      end
      default: main_cnt = '0;
    endcase
  end

  logic ext_valid;
  logic mem_use;

  always_comb begin
    ext_valid = (grp == 2'd1) || (grp == 2'd2 && mid[2] && !low[2]);
    unique case (grp)
      2'd1:    mem_use = (low == 3'd6) ^ (mid == 3'd6);
      2'd2:    mem_use = (low == 3'd6);
      2'd0:    mem_use = (mid == 3'd6) && (low == 3'd4 || low == 3'd5 || low == 3'd6);
      default: mem_use = 1'b0;
    endcase
  end

  always_comb begin
    imm_cnt   = '0;
    need_disp = 1'b0;
    ext_bad   = 1'b0;
    unique case (space)
      SP_EXT: begin
        ext_bad = !ext_valid;
        imm_cnt = (grp == 2'd1 && low == 3'd3) ? 2'd2 : 2'd0;
      end
      SP_INDEX: begin
        imm_cnt   = main_cnt;
        need_disp = mem_use;
      end
      default: imm_cnt = main_cnt;
    endcase
  end
endmodule

// File: rtl/ifr_frame_assembler.sv
module ifr_frame_assembler
  import ifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              emit,
  output frame_rec_t        rec
);
  frame_state_e      state, n_state;
  rec_class_e        w_cls, n_cls;
  logic [BYTE_W-1:0] w_op, n_op, w_disp, n_disp;
  logic [IMM_W-1:0]  w_imm, n_imm;
  logic [LEN_W-1:0]  w_len, n_len, len_n;
  logic [CNT_W-1:0]  w_cnt, n_cnt;
  logic              w_idx, n_idx;
  logic              done, drop;

  op_space_e         space;
  logic [CNT_W-1:0]  dec_cnt;
  logic              dec_disp;
  logic              dec_bad;
  logic              is_pfx;

  always_comb begin
    unique case (state)
      ST_EXT_OP: space = SP_EXT;
      ST_IDX_OP: space = SP_INDEX;
      default:   space = SP_MAIN;
    endcase
  end

  ifr_operand_decode u_dec (
    .op        (in_byte),
    .space     (space),
    .imm_cnt   (dec_cnt),
    .need_disp (dec_disp),
    .ext_bad   (dec_bad)
  );

  assign is_pfx = (in_byte == PFX_EXT) || (in_byte == PFX_IX) || (in_byte == PFX_IY);
  assign len_n  = (state == ST_IDLE) ? LEN_W'(1) : w_len + LEN_W'(1);

  always_comb begin
    n_state = state;
    n_cls   = w_cls;
    n_op    = w_op;
    n_disp  = w_disp;
    n_imm   = w_imm;
    n_idx   = w_idx;
    n_cnt   = w_cnt;
    n_len   = len_n;
    done    = 1'b0;
    drop    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        n_cls  = CLS_PLAIN;
        n_op   = in_byte;
        n_disp = '0;
        n_imm  = '0;
        n_idx  = 1'b0;
        n_cnt  = dec_cnt;
        if (in_byte == PFX_BIT)      n_state = ST_BIT_OP;
        else if (in_byte == PFX_EXT) n_state = ST_EXT_OP;
        else if (in_byte == PFX_IX || in_byte == PFX_IY) begin
          n_state = ST_IDX_OP;
          n_idx   = (in_byte == PFX_IY);
        end
        else if (dec_cnt != '0)      n_state = ST_IMM_LO;
        else                         done = 1'b1;
      end
      ST_BIT_OP: begin
        n_cls = CLS_BITOP;
        n_op  = in_byte;
        done  = 1'b1;
      end
      ST_EXT_OP: begin
        n_cls = dec_bad ? CLS_EXT_BAD : CLS_EXT;
        n_op  = in_byte;
        n_cnt = dec_cnt;
        if (dec_cnt != '0) n_state = ST_IMM_LO;
        else               done = 1'b1;
      end
      ST_IDX_OP: begin
        if (is_pfx) begin
          drop    = 1'b1;
          done    = 1'b1;
          n_len   = LEN_W'(1);
          n_idx   = (in_byte == PFX_IY);
          n_state = (in_byte == PFX_EXT) ? ST_EXT_OP : ST_IDX_OP;
        end else if (in_byte == PFX_BIT) begin
          n_cls   = CLS_INDEX_BIT;
          n_state = ST_IDXB_DISP;
        end else begin
          n_cls = CLS_INDEX;
          n_op  = in_byte;
          n_cnt = dec_cnt;
          if (dec_disp)           n_state = ST_DISP;
          else if (dec_cnt != '0) n_state = ST_IMM_LO;
          else                    done = 1'b1;
        end
      end
      ST_IDXB_DISP: begin
        n_disp  = in_byte;
        n_state = ST_IDXB_OP;
      end
      ST_IDXB_OP: begin
        n_op = in_byte;
        done = 1'b1;
      end
      ST_DISP: begin
        n_disp = in_byte;
        if (w_cnt != '0) n_state = ST_IMM_LO;
        else             done = 1'b1;
      end
      ST_IMM_LO: begin
        n_imm = {{(IMM_W-BYTE_W){1'b0}}, in_byte};
        if (w_cnt == 2'd2) n_state = ST_IMM_HI;
        else               done = 1'b1;
      end
      ST_IMM_HI: begin
        n_imm = {in_byte, w_imm[BYTE_W-1:0]};
        done  = 1'b1;
      end
      default: n_state = ST_IDLE;
    endcase
    if (done && !drop) n_state = ST_IDLE;
  end

  always_comb begin
    if (drop) begin
      rec.cls   = CLS_DROPPED;
      rec.op    = w_idx ? PFX_IY : PFX_IX;
      rec.disp  = '0;
      rec.imm   = '0;
      rec.len   = LEN_W'(1);
      rec.idx_y = w_idx;
    end else begin
      rec.cls   = n_cls;
      rec.op    = n_op;
      rec.disp  = n_disp;
      rec.imm   = n_imm;
      rec.len   = len_n;
      rec.idx_y = n_idx;
    end
  end

  assign emit = take && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      w_cls  <= CLS_PLAIN;
      w_op   <= '0;
      w_disp <= '0;
      w_imm  <= '0;
      w_len  <= '0;
      w_cnt  <= '0;
      w_idx  <= 1'b0;
    end else if (take) begin
      state  <= n_state;
      w_cls  <= n_cls;
      w_op   <= n_op;
      w_disp <= n_disp;
      w_imm  <= n_imm;
      w_len  <= n_len;
      w_cnt  <= n_cnt;
      w_idx  <= n_idx;
    end
  end
endmodule

// File: rtl/ifr_out_stage.sv
module ifr_out_stage
  import ifr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  frame_rec_t rec_in,
  input  logic       out_ready,
  output logic       out_valid,
  output frame_rec_t rec_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rec_out   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_out   <= rec_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prefix_framer.sv
module prefix_framer
  import ifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        rec_class,
  output logic [BYTE_W-1:0] rec_opcode,
  output logic [BYTE_W-1:0] rec_disp,
  output logic [IMM_W-1:0]  rec_imm,
  output logic [LEN_W-1:0]  rec_len,
  output logic              rec_idx_y
);
  logic       take;
  logic       emit;
  frame_rec_t asm_rec;
  frame_rec_t held;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  ifr_frame_assembler u_asm (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .in_byte (in_byte),
    .emit    (emit),
    .rec     (asm_rec)
  );

  ifr_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .rec_in    (asm_rec),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_out   (held)
  );

  assign rec_class  = held.cls;
  assign rec_opcode = held.op;
  assign rec_disp   = held.disp;
  assign rec_imm    = held.imm;
  assign rec_len    = held.len;
  assign rec_idx_y  = held.idx_y;
endmodule

// File: rtl/prefix_framer_checker.sv
module prefix_framer_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  rec_class,
  input logic [7:0]  rec_opcode,
  input logic [7:0]  rec_disp,
  input logic [15:0] rec_imm,
  input logic [2:0]  rec_len,
  input logic        rec_idx_y
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(rec_class) && $stable(rec_opcode)
      && $stable(rec_disp) && $stable(rec_imm) && $stable(rec_len) && $stable(rec_idx_y));

  assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_bitop_len_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && rec_class == 3'd1 |-> rec_len == 3'd2 && rec_imm == 16'h0);

  assert_bad_ext_len_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && rec_class == 3'd6 |-> rec_len == 3'd2 && rec_imm == 16'h0);

  assert_dropped_shape_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && rec_class == 3'd5 |-> rec_len == 3'd1
      && (rec_opcode == 8'hDD || rec_opcode == 8'hFD) && rec_idx_y == rec_opcode[5]);

  assert_index_bit_len_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid && rec_class == 3'd4 |-> rec_len == 3'd4);
endmodule

bind prefix_framer prefix_framer_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .rec_class  (rec_class),
  .rec_opcode (rec_opcode),
  .rec_disp   (rec_disp),
  .rec_imm    (rec_imm),
  .rec_len    (rec_len),
  .rec_idx_y  (rec_idx_y)
);

// File: tb/prefix_framer_bench.sv
`timescale 1ns/1ps
module prefix_framer_bench;
  localparam int K_PLAIN = 0, K_BIT = 1, K_EXT = 2, K_IDX = 3, K_IDXB = 4, K_DROP = 5, K_BAD = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  rec_class;
  logic [7:0]  rec_opcode;
  logic [7:0]  rec_disp;
  logic [15:0] rec_imm;
  logic [2:0]  rec_len;
  logic        rec_idx_y;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  prefix_framer u_prefix_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .rec_class(rec_class),
    .rec_opcode(rec_opcode), .rec_disp(rec_disp), .rec_imm(rec_imm),
    .rec_len(rec_len), .rec_idx_y(rec_idx_y)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_rec(input int cls, input logic [7:0] op, input logic [7:0] d,
                            input logic [15:0] imm, input int len, input bit iy,
                            input string tag);
    int waited = 0;
    @(negedge clk);
    while (!out_valid && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    check(out_valid && rec_class == cls[2:0] && rec_opcode == op && rec_disp == d
          && rec_imm == imm && rec_len == len[2:0] && rec_idx_y == iy, tag,
          $sformatf("v=%0b cls=%0d op=%h d=%h imm=%h len=%0d iy=%0b", out_valid, rec_class,
                    rec_opcode, rec_disp, rec_imm, rec_len, rec_idx_y),
          $sformatf("v=1 cls=%0d op=%h d=%h imm=%h len=%0d iy=%0b", cls, op, d, imm, len, iy));
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(!out_valid && in_ready, "R1",
          $sformatf("out_valid=%0b in_ready=%0b", out_valid, in_ready), "out_valid=0 in_ready=1");
  endtask

  task automatic t_plain();
    send(8'h00); expect_rec(K_PLAIN, 8'h00, 8'h00, 16'h0000, 1, 0, "R3 nop");
    send(8'h76); expect_rec(K_PLAIN, 8'h76, 8'h00, 16'h0000, 1, 0, "R3 halt");
  endtask

  task automatic t_imm1();
    send(8'h18); send(8'hF0); expect_rec(K_PLAIN, 8'h18, 8'h00, 16'h00F0, 2, 0, "R4 rel jump");
    send(8'h3E); send(8'h5A); expect_rec(K_PLAIN, 8'h3E, 8'h00, 16'h005A, 2, 0, "R4 load imm");
    send(8'hD3); send(8'h7F); expect_rec(K_PLAIN, 8'hD3, 8'h00, 16'h007F, 2, 0, "R4 port out");
    send(8'hFE); send(8'h01); expect_rec(K_PLAIN, 8'hFE, 8'h00, 16'h0001, 2, 0, "R4 compare");
  endtask

  task automatic t_imm2();
    send(8'h21); send(8'h34); send(8'h12); expect_rec(K_PLAIN, 8'h21, 8'h00, 16'h1234, 3, 0, "R5 pair load");
    send(8'hCD); send(8'hCD); send(8'hAB); expect_rec(K_PLAIN, 8'hCD, 8'h00, 16'hABCD, 3, 0, "R5 call");
    send(8'hC2); send(8'h00); send(8'h80); expect_rec(K_PLAIN, 8'hC2, 8'h00, 16'h8000, 3, 0, "R5 cond jump");
    send(8'h32); send(8'h11); send(8'h22); expect_rec(K_PLAIN, 8'h32, 8'h00, 16'h2211, 3, 0, "R5 abs store");
  endtask

  task automatic t_bitop();
    send(8'hCB); send(8'h46); expect_rec(K_BIT, 8'h46, 8'h00, 16'h0000, 2, 0, "R6 bit op");
    send(8'hCB); send(8'hED); expect_rec(K_BIT, 8'hED, 8'h00, 16'h0000, 2, 0, "R6 bit op prefix-like");
  endtask

  task automatic t_ext();
    send(8'hED); send(8'h43); send(8'h78); send(8'h56);
    expect_rec(K_EXT, 8'h43, 8'h00, 16'h5678, 4, 0, "R7 ext abs store");
    send(8'hED); send(8'hB0); expect_rec(K_EXT, 8'hB0, 8'h00, 16'h0000, 2, 0, "R7 block op");
    send(8'hED); send(8'h44); expect_rec(K_EXT, 8'h44, 8'h00, 16'h0000, 2, 0, "R7 negate");
  endtask

  task automatic t_ext_bad();
    send(8'hED); send(8'h00); expect_rec(K_BAD, 8'h00, 8'h00, 16'h0000, 2, 0, "R8 grp0");
    send(8'hED); send(8'h80); expect_rec(K_BAD, 8'h80, 8'h00, 16'h0000, 2, 0, "R8 grp2 low mid");
    send(8'hED); send(8'hA4); expect_rec(K_BAD, 8'hA4, 8'h00, 16'h0000, 2, 0, "R8 grp2 low4");
    send(8'hED); send(8'hC3); expect_rec(K_BAD, 8'hC3, 8'h00, 16'h0000, 2, 0, "R8 grp3");
  endtask

  task automatic t_index();
    send(8'hDD); send(8'h21); send(8'h00); send(8'h40);
    expect_rec(K_IDX, 8'h21, 8'h00, 16'h4000, 4, 0, "R9 X pair load");
    send(8'hFD); send(8'hE9); expect_rec(K_IDX, 8'hE9, 8'h00, 16'h0000, 2, 1, "R9 Y jump");
    send(8'hDD); send(8'h84); expect_rec(K_IDX, 8'h84, 8'h00, 16'h0000, 2, 0, "R9 no mem operand");
  endtask

  task automatic t_index_disp();
    send(8'hDD); send(8'h7E); send(8'hFB);
    expect_rec(K_IDX, 8'h7E, 8'hFB, 16'h0000, 3, 0, "R10 load from mem");
    send(8'hFD); send(8'h70); send(8'h05);
    expect_rec(K_IDX, 8'h70, 8'h05, 16'h0000, 3, 1, "R10 store to mem");
    send(8'hDD); send(8'h86); send(8'h10);
    expect_rec(K_IDX, 8'h86, 8'h10, 16'h0000, 3, 0, "R10 alu mem");
    send(8'hDD); send(8'h34); send(8'h80);
    expect_rec(K_IDX, 8'h34, 8'h80, 16'h0000, 3, 0, "R10 inc mem");
    send(8'hDD); send(8'h36); send(8'h02); send(8'h99);
    expect_rec(K_IDX, 8'h36, 8'h02, 16'h0099, 4, 0, "R10 disp before imm");
    send(8'hDD); send(8'h76); expect_rec(K_IDX, 8'h76, 8'h00, 16'h0000, 2, 0, "R10 halt no disp");
    send(8'h00); expect_rec(K_PLAIN, 8'h00, 8'h00, 16'h0000, 1, 0, "R10 after halt");
  endtask

  task automatic t_drop();
    send(8'hDD); send(8'hFD);
    expect_rec(K_DROP, 8'hDD, 8'h00, 16'h0000, 1, 0, "R11 dropped X");
    send(8'h21); send(8'h34); send(8'h12);
    expect_rec(K_IDX, 8'h21, 8'h00, 16'h1234, 4, 1, "R11 restart Y");
    send(8'hFD); send(8'hED);
    expect_rec(K_DROP, 8'hFD, 8'h00, 16'h0000, 1, 1, "R11 dropped Y");
    send(8'h4B); send(8'h01); send(8'h02);
    expect_rec(K_EXT, 8'h4B, 8'h00, 16'h0201, 4, 0, "R11 restart ext");
    send(8'hFD); send(8'hDD);
    expect_rec(K_DROP, 8'hFD, 8'h00, 16'h0000, 1, 1, "R11 dropped before X");
    send(8'hDD);
    expect_rec(K_DROP, 8'hDD, 8'h00, 16'h0000, 1, 0, "R11 repeated X");
    send(8'h23); expect_rec(K_IDX, 8'h23, 8'h00, 16'h0000, 2, 0, "R11 final X");
  endtask

  task automatic t_index_bit();
    send(8'hFD); send(8'hCB); send(8'h05); send(8'h46);
    expect_rec(K_IDXB, 8'h46, 8'h05, 16'h0000, 4, 1, "R12 Y bit form");
    send(8'hDD); send(8'hCB); send(8'hFE); send(8'hC6);
    expect_rec(K_IDXB, 8'hC6, 8'hFE, 16'h0000, 4, 0, "R12 X bit form");
  endtask

  task automatic t_stall();
    bit ok = 1'b1;
    send(8'h00);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h3E;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (in_ready || !out_valid || rec_opcode != 8'h00 || rec_len != 3'd1) ok = 1'b0;
    end
    check(ok, "R2 stall", $sformatf("ready=%0b valid=%0b", in_ready, out_valid),
          "ready=0 valid=1 record held");
    out_ready = 1'b1;
    #1;
    check(in_ready, "R2 pass-through ready", $sformatf("%0b", in_ready), "1");
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    send(8'h12);
    expect_rec(K_PLAIN, 8'h3E, 8'h00, 16'h0012, 2, 0, "R2 byte after stall");
  endtask

  task automatic t_reset_mid();
    send(8'hDD);
    send(8'h36);
    do_reset();
    send(8'h00);
    expect_rec(K_PLAIN, 8'h00, 8'h00, 16'h0000, 1, 0, "R1 reset mid instruction");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_imm1();
    t_imm2();
    t_bitop();
    t_ext();
    t_ext_bad();
    t_index();
    t_index_disp();
    t_drop();
    t_index_bit();
    t_stall();
    t_reset_mid();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule